// File: doc/BRIEF.md
# Host-DSP Double-Buffered Data Port

This block connects an 8-bit host bus to a 24-bit DSP core bus and moves whole 24-bit words in both directions. The host writes a word one byte at a time into three staging bytes (high, middle, low). Writing the low byte last marks the word as complete. The DSP writes a full 24-bit word into a single transmit register. Each direction copies its staged word into the reader's register on its own. The copy happens only when the sender's empty flag and the receiver's full flag are both clear, and the copy then sets both flags.

The DSP owns a small control register. It holds the receive and transmit interrupt enables, a command interrupt enable that is stored but has no function here, and two general-purpose host flags that are driven out as pins. Interrupt requests come straight from the internal flags gated by their enables. The DSP's view of its own receive-full and transmit-empty flags lags the internal state by two clock cycles. Software that polls right after a write therefore sees the old value.

Top module: `host_dsp_port`

## Requirements
- R1: After a synchronous active-low reset, h_txe=1, d_txe=1, h_rxf=0, d_rxf=0, irq_rx=0, irq_tx=0, all data outputs read 0, and the control register reads 0.
- R2: A host write stores h_wdata in the byte picked by h_sel (0 low, 1 middle, 2 high; 3 selects nothing). A write with h_sel=0 clears h_txe on the next cycle. If a host-to-DSP copy happens in that same cycle, the write wins.
- R3: When h_txe=0 and the internal DSP receive-full flag is 0, the next edge copies {high,middle,low} into d_rx_data and sets both flags. The copy takes the bytes as they stood before that edge.
- R4: A DSP receive read (d_rx_rd) clears the internal receive-full flag. d_rx_data does not change while that flag stays set.
- R5: A DSP transmit write (d_tx_wr) loads d_tx_wdata and clears the internal transmit-empty flag on the next cycle. If a DSP-to-host copy happens in that same cycle, the write wins and the copy takes the old word.
- R6: When the internal transmit-empty flag is 0 and h_rxf=0, the next edge copies the DSP transmit word into the host receive bytes and sets both flags. h_rdata shows the byte picked by h_sel (0 low, 1 middle, 2 high), or 0 when h_sel=3.
- R7: A host read (h_rd) with h_sel=0 clears h_rxf. Reads of the other bytes leave it unchanged.
- R8: A control write keeps bits 4:0 of d_ctl_wdata (bit 0 receive IE, bit 1 transmit IE, bit 2 command IE, bit 3 host flag 2, bit 4 host flag 3). Bits 15:5 always read 0. hflag[0] is bit 3 and hflag[1] is bit 4.
- R9: irq_rx equals internal receive-full AND control bit 0. irq_tx equals internal transmit-empty AND control bit 1.
- R10: d_rxf and d_txe equal the internal flags as they were two cycles earlier.
- R11: When both directions are ready in the same cycle, both copies happen on the same edge. Each direction copies at most once per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_sel | input | 2 | Host byte select: 0 low, 1 middle, 2 high, 3 none |
| h_wr | input | 1 | Host byte write strobe |
| h_rd | input | 1 | Host byte read strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host receive byte picked by h_sel |
| h_txe | output | 1 | Host transmit staging empty |
| h_rxf | output | 1 | Host receive bytes full |
| d_rx_rd | input | 1 | DSP read of the receive word |
| d_rx_data | output | 24 | DSP receive word |
| d_tx_wr | input | 1 | DSP write of the transmit word |
| d_tx_wdata | input | 24 | DSP transmit word |
| d_ctl_wr | input | 1 | DSP control register write |
| d_ctl_wdata | input | 16 | Control write data |
| d_ctl_rdata | output | 16 | Control register read-back |
| d_rxf | output | 1 | DSP-visible receive-full flag (two-cycle lag) |
| d_txe | output | 1 | DSP-visible transmit-empty flag (two-cycle lag) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| hflag | output | 2 | Host flags from control bits 3 and 4 |

## Verification
The assertions assume reset is held low for at least two clock edges, so the two-cycle lag check never looks back into unreset history. The write-wins properties are guarded so they only claim a flag set when no same-cycle write to that side competes. The stimulus drives every strobe independently and at random, including writes into full staging registers and writes that collide with copies. The bench's cycle model encodes the write-wins rule, so those collisions are checked rather than avoided. Reset is always held for several cycles.

// File: rtl/hdp_pkg.sv
// Shared constants for the host/DSP data port: control register bit map.
package hdp_pkg;
    localparam int CTL_RX_IE  = 0;
    localparam int CTL_TX_IE  = 1;
    localparam int CTL_CMD_IE = 2;
    localparam int CTL_HF_LO  = 3;
    localparam int CTL_HF_HI  = 4;
    localparam int CTL_USED   = 5;
endpackage

// File: rtl/hdp_flag_delay.sv
// Delays a status flag by DLY register stages so the DSP sees it late.
// Assumes DLY >= 0; RST_VAL is the flag's reset value, loaded into every stage.
module hdp_flag_delay #(
    parameter int   DLY     = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    output logic flag_out
);
    generate
        if (DLY == 0) begin : g_pass
            assign flag_out = flag_in;
        end else begin : g_pipe
            logic [DLY-1:0] stage_q;
            for (genvar i = 0; i < DLY; i++) begin : g_stage
                // One register stage of the lag line.
                always_ff @(posedge clk) begin
                    if (!rst_n)      stage_q[i] <= RST_VAL;
                    else if (i == 0) stage_q[i] <= flag_in;
                    else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
            assign flag_out = stage_q[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/hdp_host_side.sv
// Host byte registers: NBYTES transmit staging bytes, NBYTES receive bytes,
// and the host transmit-empty / receive-full flags.
// Assumes byte index 0 is the low byte; writing it completes a word.
module hdp_host_side #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    parameter int SEL_W  = 2,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  h_sel,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [BYTE_W-1:0] h_wdata,
    input  logic              xfer_h2d,
    input  logic              xfer_d2h,
    input  logic [WORD_W-1:0] d2h_word,
    output logic [WORD_W-1:0] tx_word,
    output logic [BYTE_W-1:0] h_rdata,
    output logic              h_txe,
    output logic              h_rxf
);
    logic [NBYTES-1:0][BYTE_W-1:0] tx_q;
    logic [NBYTES-1:0][BYTE_W-1:0] rx_q;
    logic                          low_wr;
    logic                          low_rd;

    assign low_wr = h_wr && (h_sel == '0);
    assign low_rd = h_rd && (h_sel == '0);

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            // Staging byte b takes host data when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 tx_q[b] <= '0;
                else if (h_wr && (h_sel == SEL_W'(b)))      tx_q[b] <= h_wdata;
            end
            // Receive byte b is loaded by a DSP-to-host copy.
            always_ff @(posedge clk) begin
                if (!rst_n)        rx_q[b] <= '0;
                else if (xfer_d2h) rx_q[b] <= d2h_word[b*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    // Transmit-empty: cleared by a low-byte write (wins), set by a copy.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_txe <= 1'b1;
        else if (low_wr)   h_txe <= 1'b0;
        else if (xfer_h2d) h_txe <= 1'b1;
    end

    // Receive-full: set by a copy, cleared by a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_rxf <= 1'b0;
        else if (xfer_d2h) h_rxf <= 1'b1;
        else if (low_rd)   h_rxf <= 1'b0;
    end

    // Read mux: selected receive byte, zero for an unused select code.
    always_comb begin
        h_rdata = '0;
        for (int b = 0; b < NBYTES; b++)
            if (h_sel == SEL_W'(b)) h_rdata = rx_q[b];
    end

    assign tx_word = tx_q;

    // R2
    low_write_clears_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr |=> !h_txe);
    // R7
    low_read_clears_rxf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_rd && h_rxf) |=> !h_rxf);
endmodule

// File: rtl/hdp_dsp_side.sv
// DSP registers: receive word, transmit word, control register, the internal
// receive-full / transmit-empty flags, their lagged DSP view and interrupts.
// Assumes copies are only requested by the top when the flags allow them.
module hdp_dsp_side
    import hdp_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int CTL_W    = 16,
    parameter int STAT_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_rx_rd,
    input  logic              d_tx_wr,
    input  logic [WORD_W-1:0] d_tx_wdata,
    input  logic              d_ctl_wr,
    input  logic [CTL_W-1:0]  d_ctl_wdata,
    input  logic              xfer_h2d,
    input  logic [WORD_W-1:0] h2d_word,
    input  logic              xfer_d2h,
    output logic [WORD_W-1:0] d_rx_data,
    output logic [WORD_W-1:0] tx_word,
    output logic [CTL_W-1:0]  d_ctl_rdata,
    output logic              rxf_int,
    output logic              txe_int,
    output logic              d_rxf,
    output logic              d_txe,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic [1:0]        hflag
);
    logic [WORD_W-1:0]   rx_q;
    logic [WORD_W-1:0]   tx_q;
    logic [CTL_USED-1:0] ctl_q;

    // Receive word is loaded by a host-to-DSP copy.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (xfer_h2d) rx_q <= h2d_word;
    end

    // Receive-full: set by a copy, cleared by a DSP read.
    always_ff @(posedge clk) begin
        if (!rst_n)        rxf_int <= 1'b0;
        else if (xfer_h2d) rxf_int <= 1'b1;
        else if (d_rx_rd)  rxf_int <= 1'b0;
    end

    // Transmit word is loaded by a DSP write.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (d_tx_wr) tx_q <= d_tx_wdata;
    end

    // Transmit-empty: cleared by a DSP write (wins), set by a copy.
    always_ff @(posedge clk) begin
        if (!rst_n)        txe_int <= 1'b1;
        else if (d_tx_wr)  txe_int <= 1'b0;
        else if (xfer_d2h) txe_int <= 1'b1;
    end

    // Control register keeps only the defined low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= '0;
        else if (d_ctl_wr) ctl_q <= d_ctl_wdata[CTL_USED-1:0];
    end

    hdp_flag_delay #(.DLY(STAT_DLY), .RST_VAL(1'b0)) i_rxf_dly (
        .clk(clk), .rst_n(rst_n), .flag_in(rxf_int), .flag_out(d_rxf));
    hdp_flag_delay #(.DLY(STAT_DLY), .RST_VAL(1'b1)) i_txe_dly (
        .clk(clk), .rst_n(rst_n), .flag_in(txe_int), .flag_out(d_txe));

    assign d_rx_data   = rx_q;
    assign tx_word     = tx_q;
    assign d_ctl_rdata = CTL_W'(ctl_q);
    assign irq_rx      = rxf_int & ctl_q[CTL_RX_IE];
    assign irq_tx      = txe_int & ctl_q[CTL_TX_IE];
    assign hflag       = {ctl_q[CTL_HF_HI], ctl_q[CTL_HF_LO]};

    // R4
    rx_word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_int && $past(rxf_int)) |-> $stable(rx_q));
    // R4
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rx_rd && rxf_int) |=> !rxf_int);
    // R5
    tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_tx_wr |=> !txe_int);

    generate
        if (STAT_DLY == 2) begin : g_lag_chk
            // R10
            rxf_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                d_rxf == $past(rxf_int, 2));
            // R10
            txe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                d_txe == $past(txe_int, 2));
        end
    endgenerate
endmodule

// File: rtl/host_dsp_port.sv
// Top of the host/DSP double-buffered data port. Decides when each
// direction copies a word and wires the host and DSP register banks.
// Assumes synchronous active-low reset held for at least two edges.
module host_dsp_port #(
    parameter int BYTE_W   = 8,
    parameter int NBYTES   = 3,
    parameter int CTL_W    = 16,
    parameter int STAT_DLY = 2,
    localparam int WORD_W  = BYTE_W * NBYTES,
    localparam int SEL_W   = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  h_sel,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [BYTE_W-1:0] h_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    output logic              h_txe,
    output logic              h_rxf,
    input  logic              d_rx_rd,
    output logic [WORD_W-1:0] d_rx_data,
    input  logic              d_tx_wr,
    input  logic [WORD_W-1:0] d_tx_wdata,
    input  logic              d_ctl_wr,
    input  logic [CTL_W-1:0]  d_ctl_wdata,
    output logic [CTL_W-1:0]  d_ctl_rdata,
    output logic              d_rxf,
    output logic              d_txe,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic [1:0]        hflag
);
    logic              xfer_h2d;
    logic              xfer_d2h;
    logic [WORD_W-1:0] h_tx_word;
    logic [WORD_W-1:0] d_tx_word;
    logic              rxf_int;
    logic              txe_int;

    // Each direction copies when sender is not empty and receiver not full.
    assign xfer_h2d = !h_txe   && !rxf_int;
    assign xfer_d2h = !txe_int && !h_rxf;

    hdp_host_side #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .SEL_W(SEL_W)) i_host (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .xfer_h2d(xfer_h2d), .xfer_d2h(xfer_d2h),
        .d2h_word(d_tx_word), .tx_word(h_tx_word), .h_rdata(h_rdata),
        .h_txe(h_txe), .h_rxf(h_rxf));

    hdp_dsp_side #(.WORD_W(WORD_W), .CTL_W(CTL_W), .STAT_DLY(STAT_DLY)) i_dsp (
        .clk(clk), .rst_n(rst_n), .d_rx_rd(d_rx_rd), .d_tx_wr(d_tx_wr),
        .d_tx_wdata(d_tx_wdata), .d_ctl_wr(d_ctl_wr), .d_ctl_wdata(d_ctl_wdata),
        .xfer_h2d(xfer_h2d), .h2d_word(h_tx_word), .xfer_d2h(xfer_d2h),
        .d_rx_data(d_rx_data), .tx_word(d_tx_word), .d_ctl_rdata(d_ctl_rdata),
        .rxf_int(rxf_int), .txe_int(txe_int), .d_rxf(d_rxf), .d_txe(d_txe),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .hflag(hflag));

    // R3
    h2d_copy_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_h2d && !(h_wr && h_sel == '0)) |=> (h_txe && rxf_int));
    // R3
    h2d_copy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_h2d |=> (d_rx_data == $past(h_tx_word)));
    // R6
    d2h_copy_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_d2h && !d_tx_wr) |=> (txe_int && h_rxf));
endmodule

// File: tb/test_host_dsp_port.sv
// Self-checking bench: a cycle model built from the requirements runs
// beside the design; outputs are compared on every falling edge.
module test_host_dsp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  h_sel = '0;
    logic        h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        h_txe, h_rxf;
    logic        d_rx_rd = 1'b0;
    logic [23:0] d_rx_data;
    logic        d_tx_wr = 1'b0;
    logic [23:0] d_tx_wdata = '0;
    logic        d_ctl_wr = 1'b0;
    logic [15:0] d_ctl_wdata = '0;
    logic [15:0] d_ctl_rdata;
    logic        d_rxf, d_txe, irq_rx, irq_tx;
    logic [1:0]  hflag;

    int tests = 0, fails = 0;
    bit done = 0;
    bit model_ok = 0;

    always #5 clk = ~clk;

    host_dsp_port i_host_dsp_port (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_txe(h_txe), .h_rxf(h_rxf),
        .d_rx_rd(d_rx_rd), .d_rx_data(d_rx_data), .d_tx_wr(d_tx_wr),
        .d_tx_wdata(d_tx_wdata), .d_ctl_wr(d_ctl_wr), .d_ctl_wdata(d_ctl_wdata),
        .d_ctl_rdata(d_ctl_rdata), .d_rxf(d_rxf), .d_txe(d_txe),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .hflag(hflag));

    // Reference model state
    logic [2:0][7:0] m_htx, m_hrx;
    logic [23:0]     m_drx, m_dtx;
    logic            m_htxe, m_hrxf, m_drxf, m_dtxe;
    logic [4:0]      m_ctl;
    logic [1:0]      m_prxf, m_ptxe;

    always @(posedge clk) begin
        logic xh, xd;
        logic [23:0] old_h, old_d;
        if (!rst_n) begin
            m_htx = '0; m_hrx = '0; m_drx = '0; m_dtx = '0;
            m_htxe = 1; m_hrxf = 0; m_drxf = 0; m_dtxe = 1;
            m_ctl = '0; m_prxf = 2'b00; m_ptxe = 2'b11;
            model_ok = 1;
        end else begin
            xh = !m_htxe && !m_drxf;
            xd = !m_dtxe && !m_hrxf;
            old_h = {m_htx[2], m_htx[1], m_htx[0]};
            old_d = m_dtx;
            m_prxf = {m_prxf[0], m_drxf};
            m_ptxe = {m_ptxe[0], m_dtxe};
            if (h_wr && h_sel != 2'd3) m_htx[h_sel] = h_wdata;
            if (h_wr && h_sel == 0) m_htxe = 0; else if (xh) m_htxe = 1;
            if (xd) m_hrxf = 1; else if (h_rd && h_sel == 0) m_hrxf = 0;
            if (xd) m_hrx = old_d;
            if (xh) m_drx = old_h;
            if (xh) m_drxf = 1; else if (d_rx_rd) m_drxf = 0;
            if (d_tx_wr) m_dtx = d_tx_wdata;
            if (d_tx_wr) m_dtxe = 0; else if (xd) m_dtxe = 1;
            if (d_ctl_wr) m_ctl = d_ctl_wdata[4:0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] s);
        return (s == 2'd3) ? 8'h00 : m_hrx[s];
    endfunction

    // Compare every output against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && model_ok && !done) begin
            chk("R2 h_txe", h_txe, m_htxe);
            chk("R7 h_rxf", h_rxf, m_hrxf);
            chk("R6 h_rdata", h_rdata, exp_rdata(h_sel));
            chk("R3 d_rx_data", d_rx_data, m_drx);
            chk("R8 d_ctl_rdata", d_ctl_rdata, {11'b0, m_ctl});
            chk("R8 hflag", hflag, {m_ctl[4], m_ctl[3]});
            chk("R10 d_rxf", d_rxf, m_prxf[1]);
            chk("R10 d_txe", d_txe, m_ptxe[1]);
            chk("R9 irq_rx", irq_rx, m_drxf & m_ctl[0]);
            chk("R9 irq_tx", irq_tx, m_dtxe & m_ctl[1]);
        end
    end

    task automatic cyc(input bit hw, input logic [1:0] hs, input logic [7:0] hd,
                       input bit hr, input bit tw, input logic [23:0] td,
                       input bit rr, input bit cw, input logic [15:0] cd);
        @(negedge clk); #2;
        h_wr = hw; h_sel = hs; h_wdata = hd; h_rd = hr;
        d_tx_wr = tw; d_tx_wdata = td; d_rx_rd = rr;
        d_ctl_wr = cw; d_ctl_wdata = cd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd3, 8'h0, 0, 0, 24'h0, 0, 0, 16'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 h_txe", h_txe, 1); chk("R1 h_rxf", h_rxf, 0);
        chk("R1 d_txe", d_txe, 1); chk("R1 d_rxf", d_rxf, 0);
        chk("R1 irq", {irq_rx, irq_tx}, 0); chk("R1 ctl", d_ctl_rdata, 0);
        chk("R1 d_rx_data", d_rx_data, 0);
        // R8 reserved bits ignored, enables on
        cyc(0, 2'd3, 0, 0, 0, 0, 0, 1, 16'hFFFF);
        idle(1);
        chk("R8 reserved zero", d_ctl_rdata, 16'h001F);
        // R2/R3 host word high, middle, low; then R10 lagged view
        cyc(1, 2'd2, 8'hAB, 0, 0, 0, 0, 0, 0);
        cyc(1, 2'd1, 8'hCD, 0, 0, 0, 0, 0, 0);
        cyc(1, 2'd0, 8'hEF, 0, 0, 0, 0, 0, 0);
        idle(3);
        chk("R3 word order", d_rx_data, 24'hABCDEF);
        // R4 DSP read clears receive-full (seen through irq_rx)
        cyc(0, 2'd3, 0, 0, 0, 0, 1, 0, 0);
        idle(1);
        chk("R4 rx cleared", irq_rx, m_drxf & m_ctl[0]);
        // R11 both directions ready in the same cycle
        cyc(1, 2'd0, 8'h11, 0, 1, 24'h123456, 0, 0, 0);
        idle(1);
        chk("R11 both copied", {h_rxf, irq_rx}, {m_hrxf, m_drxf & m_ctl[0]});
        // R5 back-to-back DSP writes collide with a copy; write wins
        cyc(1, 2'd0, 8'h22, 1, 0, 0, 1, 0, 0);
        cyc(0, 2'd3, 0, 0, 1, 24'hA5A5A5, 0, 0, 0);
        cyc(0, 2'd3, 0, 0, 1, 24'h5A5A5A, 0, 0, 0);
        idle(1);
        chk("R5 write wins", irq_tx, m_dtxe & m_ctl[1]);
        // R7 non-low read does not clear host receive-full
        cyc(0, 2'd2, 0, 1, 0, 0, 0, 0, 0);
        idle(1);
        chk("R7 high read keeps", h_rxf, m_hrxf);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 10) < 3, 2'($urandom), 8'($urandom),
                ($urandom % 10) < 3, ($urandom % 10) < 2, 24'($urandom),
                ($urandom % 4) == 0, ($urandom % 32) == 0, 16'($urandom));
        end
        idle(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule